// File: doc/BRIEF.md
# Accumulator ALU with Five Status Flags

This block is the arithmetic and logic core of a small accumulator-based processor. Each cycle it takes an operation code, the accumulator value and a second operand. It returns a result at once, with no clock in the data path. It also has a write-back qualifier that tells the surrounding datapath whether the result should be stored. The supported operations are add, add with carry, subtract, subtract with borrow, compare, AND, OR, XOR, increment and decrement.

Five status flags are computed from each result: sign, zero, half carry, parity and carry. They are held in a register that loads on the clock edge only while the flag-write enable is high. The stored carry feeds add-with-carry and subtract-with-borrow.

Increment and decrement work on the second operand. Decode can therefore route any register through the block and write the result back to that same register. These two operations leave the stored carry untouched. Wider arithmetic is left to software, which chains 8-bit steps through the stored carry.

Top module: `acc_alu`

## Requirements
- R1: Opcode 0 (add) returns acc+opnd and opcode 1 (add with carry) returns acc+opnd+stored carry, both modulo 256. The carry flag is the carry out of bit 7.
- R2: Opcode 2 (subtract) returns acc-opnd and opcode 3 (subtract with borrow) returns acc-opnd-stored carry, both modulo 256. The carry flag is set exactly when the unsigned acc is less than opnd plus the borrow-in.
- R3: Opcode 7 (compare) produces the flags that subtract would produce and holds write_en low.
- R4: For add, subtract, compare, increment and decrement, half carry (flag bit 2) is the carry out of the low-nibble sum of the adder. Subtraction adds the inverted opnd plus the inverse of the borrow-in. Increment therefore sets it when the operand's low nibble is 0xF, and decrement sets it when that nibble is nonzero.
- R5: The flag vector is {sign, zero, half carry, parity, carry} on bits 4 down to 0. Sign takes bit 7 of the result, and zero is set when all eight result bits are 0.
- R6: Parity (flag bit 1) is set when the result holds an even number of ones.
- R7: Opcode 8 (increment) returns opnd+1 and opcode 9 (decrement) returns opnd-1, both modulo 256. Both leave the carry flag unchanged.
- R8: Opcode 4 (AND) clears carry and sets half carry to the OR of bit 3 of both operands. Opcodes 5 (XOR) and 6 (OR) clear both carry and half carry.
- R9: Reset clears all flags. The flags change on a clock edge only when flag_we is high.
- R10: Opcodes 10 to 15 pass acc to result, hold write_en low and leave the flags unchanged even with flag_we high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 4 | Operation code |
| acc | input | WIDTH | Accumulator operand |
| opnd | input | WIDTH | Second operand; the source for increment and decrement |
| flag_we | input | 1 | Flag-write enable |
| result | output | WIDTH | Combinational result |
| write_en | output | 1 | High when the result is to be written back |
| flags | output | 5 | Registered {sign, zero, half carry, parity, carry} |

## Verification
The bench builds the block at its default WIDTH of 8. At this width the nibble boundary and bit 7 sit where the flag rules place them, and all 256 operand values per port can be reached. Directed pairs cover the carry and half-carry boundaries: 0x0F+1, 0xFF+1, 0x00-1 and 0x10-1. They also chain a set carry into add-with-carry, subtract-with-borrow and increment, and then into decrement of zero. A run of random operations, with random enables and random codes including the unused ones, is then checked against a reference model built from the flag rules.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] opnd,
  input  logic             flag_we,
  output logic [WIDTH-1:0] result,
  output logic             write_en,
  output logic [4:0]       flags
);
  localparam int NIB = 4;
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
                         OP_AND = 4'd4, OP_XOR = 4'd5, OP_OR  = 4'd6, OP_CMP = 4'd7,
                         OP_INC = 4'd8, OP_DEC = 4'd9;

  logic [WIDTH-1:0] x, y;
  logic             ci, cy_n, ac_n, known;
  logic [WIDTH:0]   sum;
  logic [NIB:0]     lo;
  logic [4:0]       nxt;
  logic             cy_q;

  assign cy_q = flags[0];
  assign sum  = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
  assign lo   = {1'b0, x[NIB-1:0]} + {1'b0, y[NIB-1:0]} + {{NIB{1'b0}}, ci};

  always_comb begin
    x  = acc;
    y  = opnd;
    ci = 1'b0;
    case (op)
      OP_ADC:         ci = cy_q;
      OP_SUB, OP_CMP: begin y = ~opnd; ci = 1'b1;  end
      OP_SBB:         begin y = ~opnd; ci = ~cy_q; end
      OP_INC:         begin x = opnd; y = '0; ci = 1'b1; end
      OP_DEC:         begin x = opnd; y = '1; end
      default: ;
    endcase
  end

  always_comb begin
    result   = sum[WIDTH-1:0];
    cy_n     = sum[WIDTH];
    ac_n     = lo[NIB];
    write_en = 1'b1;
    known    = 1'b1;
    case (op)
      OP_ADD, OP_ADC: ;
      OP_SUB, OP_SBB: cy_n = ~sum[WIDTH];
      OP_CMP:         begin cy_n = ~sum[WIDTH]; write_en = 1'b0; end
      OP_INC, OP_DEC: cy_n = cy_q;
      OP_AND: begin result = acc & opnd; cy_n = 1'b0; ac_n = acc[NIB-1] | opnd[NIB-1]; end
      OP_XOR: begin result = acc ^ opnd; cy_n = 1'b0; ac_n = 1'b0; end
      OP_OR:  begin result = acc | opnd; cy_n = 1'b0; ac_n = 1'b0; end
      default: begin
        result   = acc;
        write_en = 1'b0;
        known    = 1'b0;
        cy_n     = cy_q;
        ac_n     = flags[2];
      end
    endcase
  end

  assign nxt = {result[WIDTH-1], result == '0, ac_n, ~^result, cy_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flags <= '0;
    else if (flag_we && known) flags <= nxt;
  end
endmodule

module acc_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       op,
  input logic [WIDTH-1:0] acc,
  input logic             flag_we,
  input logic [WIDTH-1:0] result,
  input logic             write_en,
  input logic [4:0]       flags
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags));
  p_keep_cy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (op == 4'd8 || op == 4'd9)) |=> flags[0] == $past(flags[0]));
  p_logic_cy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op >= 4'd4 && op <= 4'd6) |=> !flags[0]);
  p_or_xor_ac_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (op == 4'd5 || op == 4'd6)) |=> !flags[2]);
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op <= 4'd9) |=> flags[3] == ($past(result) == '0));
  p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op <= 4'd9) |=> flags[4] == $past(result[WIDTH-1]));
  p_par_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op <= 4'd9) |=> flags[1] == ~^$past(result));
  p_cmp_nowb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op == 4'd7 |-> !write_en);
  p_undef_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op >= 4'd10 |-> (!write_en && result == acc));
  p_undef_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op >= 4'd10 |=> $stable(flags));
endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   op = '0;
  logic [W-1:0] acc = '0, opnd = '0;
  logic         flag_we = 1'b0;
  logic [W-1:0] result;
  logic         write_en;
  logic [4:0]   flags;

  always #2.5 clk = ~clk;

  acc_alu #(.WIDTH(W)) u0 (.clk(clk), .rst_n(rst_n), .op(op), .acc(acc), .opnd(opnd),
    .flag_we(flag_we), .result(result), .write_en(write_en), .flags(flags));

  typedef struct {
    logic [7:0] res;
    logic       wen;
    logic [4:0] flg;
    string      tag;
  } item_t;

  item_t q[$];
  logic [4:0] mf = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      0, 1:    return "R1 R4";
      2, 3:    return "R2 R4";
      7:       return "R3 R4";
      4, 5, 6: return "R8";
      8, 9:    return "R7 R4";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b, input logic we);
    item_t it;
    int s, c, bw;
    logic [7:0] r;
    logic cy, ac, wen;
    c = mf[0]; cy = mf[0]; ac = mf[2]; wen = 1; r = a;
    case (o)
      0, 1: begin
        if (o == 0) c = 0;
        s = a + b + c; r = s[7:0]; cy = s > 255;
        ac = ((a & 15) + (b & 15) + c) > 15;
      end
      2, 3, 7: begin
        bw = (o == 3) ? int'(mf[0]) : 0;
        s = int'(a) - int'(b) - bw; r = s[7:0]; cy = s < 0;
        ac = ((a & 15) + ((~b) & 15) + (1 - bw)) > 15;
        if (o == 7) wen = 0;
      end
      4: begin r = a & b; cy = 0; ac = a[3] | b[3]; end
      5: begin r = a ^ b; cy = 0; ac = 0; end
      6: begin r = a | b; cy = 0; ac = 0; end
      8: begin r = b + 8'd1; ac = (b & 15) == 15; end
      9: begin r = b - 8'd1; ac = (b & 15) != 0; end
      default: begin r = a; wen = 0; end
    endcase
    it.res = r; it.wen = wen; it.tag = tag_of(o);
    if (we && o <= 9) mf = {r[7], r == 0, ac, ~^r, cy};
    it.flg = mf;
    @(negedge clk);
    op = o; acc = a; opnd = b; flag_we = we;
    q.push_back(it);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk); #2;
      if (q.size() > 0) begin
        it = q[0];
        chk(result == it.res, {it.tag, " result"}, result, it.res);
        chk(write_en == it.wen, {it.tag, " R3 write_en"}, write_en, it.wen);
        @(posedge clk); #1;
        chk(flags == it.flg, {it.tag, " R5 R6 R9 flags"}, flags, it.flg);
        void'(q.pop_front());
      end
    end
  end

  initial begin : watchdog
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    chk(flags == 5'd0, "R9 reset flags", flags, 0);
    rst_n = 1'b1;
    drive(0, 8'h0F, 8'h01, 1);
    drive(0, 8'hFF, 8'h01, 1);
    drive(1, 8'h10, 8'h20, 1);
    drive(0, 8'h80, 8'h80, 1);
    drive(3, 8'h05, 8'h01, 1);
    drive(2, 8'h05, 8'h09, 1);
    drive(8, 8'h00, 8'hFF, 1);
    drive(9, 8'h00, 8'h00, 1);
    drive(9, 8'h33, 8'h10, 1);
    drive(7, 8'h42, 8'h42, 1);
    drive(2, 8'h10, 8'h01, 1);
    drive(4, 8'h08, 8'h00, 1);
    drive(5, 8'h5A, 8'h5A, 1);
    drive(6, 8'h01, 8'h02, 1);
    drive(0, 8'hFF, 8'hFF, 0);
    drive(12, 8'h77, 8'h00, 1);
    drive(15, 8'h00, 8'h00, 1);
    for (int i = 0; i < 400; i++)
      drive(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 1'($urandom_range(0, 3) != 0));
    @(negedge clk); flag_we = 1'b0; op = 4'd0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule